// File: doc/BRIEF.md
# Hierarchical Statechart Step Engine

This block runs a statechart in hardware and advances it by one microstep per clock. Every state owns one bit of an active-state vector. The shape of the chart is fixed by parameters: for each transition a source state index, a mask of the event ids that trigger it (zero means eventless), a target mask, an exit mask and a priority-conflict mask; for each state its parent index, a flag for parallel states, and the mask of its initial children. States must be numbered so that every parent has a lower index than its children, with the root at index 0.

Events come in through an id and a write strobe into a small internal queue. The engine alternates between two phases held in an enumerated register. In PH_EVENTLESS it takes eventless transitions, and it stays there as long as at least one transition fires. In PH_EVENT it pops one event from the queue and takes the event-driven transitions that match it, then returns to PH_EVENTLESS. After reset the root is forced into the entry set, so the first enabled step builds the initial configuration. The default chart has these states: root(0), A(1), a parallel P(2) with regions P1(3: P1a 4, P1b 5) and P2(6: P2a 7, P2b 8), and a top-level final F(9). Its event ids are go=0, go.fast=1, flip=2, done=3 and tick=4. Its transitions, in priority order, are:
- T0: A -flip-> P1b
- T1: A -go|go.fast-> P
- T2: P1a -flip-> P1b
- T3: P2a -flip-> P2b
- T4: P2b -eventless-> P2a
- T5: P -any event-> A (conflicts with T2 and T3)
- T6: A -done-> F

Top module: `stc_engine`

## Requirements
- R1: While reset is applied, active_o is all zero and done_o and err_o are 0. The reset asserts at once and releases two clock edges after arst_i falls.
- R2: The first enabled step after reset enters the root and its initial child only, giving active_o = 0x003 in the default chart.
- R3: An event id triggers exactly the transitions whose event mask has that id's bit set. go.fast (id 1) drives T1 from A, and the any-event transition T5 from P.
- R4: An event step is followed by eventless steps for as long as each one selects a transition. flip in 0x0DD gives 0x16D on the step edge and 0x0ED one edge later.
- R5: A transition is blocked when a lower-index transition marked in its conflict mask is selected in the same step. Transitions without such a conflict fire together: flip in 0x0DD takes T2 and T3 and not T5.
- R6: Entering a compound state enters its initial child, and entering a parallel state enters every region: go in A gives 0x0DD.
- R7: A target below a compound parent enters all its ancestors. It suppresses the default child of that parent, while other regions still complete by default: flip in A gives 0x0ED.
- R8: An event that no active transition matches is discarded and leaves active_o unchanged (tick in A keeps 0x003).
- R9: While en_i is low the configuration holds and queued events wait. They are processed once en_i returns high.
- R10: done_o is high while a top-level final state is active (F = bit 9). The configuration then stays frozen and the queue is not read.
- R11: Queued events are processed in arrival order: go.fast then flip from A ends in 0x0ED.
- R12: The queue holds QDEPTH (4) events and drops writes while full. err_o equals the queue-full flag delayed by one clock.
- R13: Asserting arst_i in the middle of operation clears the configuration, the queue and err_o, and the chart re-initialises to 0x003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_i | input | 1 | Asynchronous reset, active high |
| en_i | input | 1 | Step enable |
| ev_id_i | input | EW (3) | Event id to enqueue |
| ev_push_i | input | 1 | Enqueue strobe for ev_id_i |
| active_o | output | NS (10) | Active-state vector |
| done_o | output | 1 | A top-level final state is active |
| err_o | output | 1 | Registered queue-full flag |

## Verification
The hardest situation to create is a step where two transitions in separate parallel regions fire together, while a higher-index any-event transition out of the enclosing parallel state is also enabled and has to lose on its conflict mask. The bench gets there by entering P shallowly with go, so that both regions sit in their default children, and then queueing flip. Filling the queue is equally indirect, because a running engine drains it. The bench therefore first drives the chart into the final state, where the engine stalls for good, and only then pushes events until err_o rises.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic {
        PH_EVENT     = 1'b0,
        PH_EVENTLESS = 1'b1
    } phase_e;

    localparam int DEF_NS = 10;
    localparam int DEF_NT = 7;
    localparam int DEF_NE = 5;

    // Per-transition source state, index 0 first.
    localparam int DEF_TR_SRC [DEF_NT] = '{1, 1, 4, 7, 8, 2, 1};

    // Packed tables, written from the highest transition (T6) down to T0.
    localparam logic [DEF_NT-1:0][DEF_NE-1:0] DEF_TR_EVT =
        {5'b01000, 5'b11111, 5'b00000, 5'b00100, 5'b00100, 5'b00011, 5'b00100};
    localparam logic [DEF_NT-1:0][DEF_NS-1:0] DEF_TR_TGT =
        {10'h200, 10'h002, 10'h080, 10'h100, 10'h020, 10'h004, 10'h020};
    localparam logic [DEF_NT-1:0][DEF_NS-1:0] DEF_TR_EXIT =
        {10'h002, 10'h1FC, 10'h100, 10'h080, 10'h010, 10'h002, 10'h002};
    localparam logic [DEF_NT-1:0][DEF_NT-1:0] DEF_TR_CONF =
        {7'h03, 7'h0C, 7'h00, 7'h00, 7'h00, 7'h01, 7'h00};

    // Per-state parent (-1 for the root), index 0 first.
    localparam int DEF_ST_PARENT [DEF_NS] = '{-1, 0, 0, 2, 3, 3, 2, 6, 6, 0};
    localparam logic [DEF_NS-1:0] DEF_ST_PAR      = 10'h004;
    localparam logic [DEF_NS-1:0] DEF_ST_TOPFINAL = 10'h200;
    // Initial-children mask per state, state 9 first.
    localparam logic [DEF_NS-1:0][DEF_NS-1:0] DEF_ST_INIT =
        {10'h000, 10'h000, 10'h000, 10'h080, 10'h000,
         10'h000, 10'h010, 10'h048, 10'h000, 10'h002};

endpackage

// File: rtl/stc_event_queue.sv
module stc_event_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 3,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic          wr_ok,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          rd_ok;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/stc_trans_select.sv
module stc_trans_select #(
    parameter int NS = 10,
    parameter int NT = 7,
    parameter int NE = 5,
    parameter int EW = 3,
    parameter int TR_SRC [NT] = '{default: 0},
    parameter logic [NT-1:0][NE-1:0] TR_EVT  = '0,
    parameter logic [NT-1:0][NT-1:0] TR_CONF = '0
) (
    input  logic [NS-1:0] active,
    input  logic          eventless,
    input  logic          ev_valid,
    input  logic [EW-1:0] ev_id,
    output logic [NT-1:0] sel
);
    always_comb begin
        logic [NT-1:0] lower;
        logic          trig;
        sel = '0;
        for (int t = 0; t < NT; t++) begin
            lower = (NT'(1) << t) - NT'(1);
            if (TR_EVT[t] == '0) trig = eventless;
            else                 trig = !eventless && ev_valid && TR_EVT[t][ev_id];
            sel[t] = active[TR_SRC[t]] && trig && ((sel & TR_CONF[t] & lower) == '0);
        end
    end
endmodule

// File: rtl/stc_config_next.sv
module stc_config_next #(
    parameter int NS = 10,
    parameter int NT = 7,
    parameter logic [NT-1:0][NS-1:0] TR_TGT  = '0,
    parameter logic [NT-1:0][NS-1:0] TR_EXIT = '0,
    parameter int ST_PARENT [NS] = '{default: -1},
    parameter logic [NS-1:0]           ST_PAR  = '0,
    parameter logic [NS-1:0][NS-1:0]   ST_INIT = '0
) (
    input  logic [NS-1:0] active,
    input  logic [NT-1:0] sel,
    input  logic          init,
    output logic [NS-1:0] next
);
    localparam int SIW = (NS > 1) ? $clog2(NS) : 1;

    // desc[i][j]: state j is state i or lies below it.
    function automatic logic [NS-1:0][NS-1:0] f_desc();
        logic [NS-1:0][NS-1:0] m;
        int k;
        m = '0;
        for (int j = 0; j < NS; j++) begin
            k = j;
            for (int d = 0; d < NS; d++) begin
                if (k >= 0) begin
                    m[k][j] = 1'b1;
                    k = ST_PARENT[k];
                end
            end
        end
        return m;
    endfunction

    function automatic logic [NS-1:0][NS-1:0] f_child();
        logic [NS-1:0][NS-1:0] m;
        m = '0;
        for (int j = 0; j < NS; j++)
            if (ST_PARENT[j] >= 0) m[ST_PARENT[j]][j] = 1'b1;
        return m;
    endfunction

    localparam logic [NS-1:0][NS-1:0] DESC  = f_desc();
    localparam logic [NS-1:0][NS-1:0] CHILD = f_child();

    always_comb begin
        logic [NS-1:0]  exit_v, tgt, up, keep, ce;
        logic [SIW-1:0] p;
        exit_v = '0;
        tgt    = '0;
        for (int t = 0; t < NT; t++) begin
            if (sel[t]) begin
                exit_v = exit_v | TR_EXIT[t];
                tgt    = tgt | TR_TGT[t];
            end
        end
        exit_v = exit_v & active;
        keep   = active & ~exit_v;
        for (int i = 0; i < NS; i++) up[i] = |(tgt & DESC[i]);
        // Parents precede children, so one ascending sweep completes entry.
        ce = '0;
        for (int i = 0; i < NS; i++) begin
            p = SIW'((ST_PARENT[i] < 0) ? 0 : ST_PARENT[i]);
            if (ST_PARENT[i] < 0)
                ce[i] = up[i] || init;
            else if (ST_PAR[p])
                ce[i] = up[i] || ce[p];
            else
                ce[i] = up[i] || (ce[p] && ST_INIT[p][i] && (((keep | up) & CHILD[p]) == '0));
        end
        next = keep | ce;
    end
endmodule

// File: rtl/stc_engine.sv
module stc_engine import stc_pkg::*; #(
    parameter int NS     = DEF_NS,
    parameter int NT     = DEF_NT,
    parameter int NE     = DEF_NE,
    parameter int EW     = (NE > 1) ? $clog2(NE) : 1,
    parameter int QDEPTH = 4,
    parameter int TR_SRC [NT] = DEF_TR_SRC,
    parameter logic [NT-1:0][NE-1:0] TR_EVT  = DEF_TR_EVT,
    parameter logic [NT-1:0][NS-1:0] TR_TGT  = DEF_TR_TGT,
    parameter logic [NT-1:0][NS-1:0] TR_EXIT = DEF_TR_EXIT,
    parameter logic [NT-1:0][NT-1:0] TR_CONF = DEF_TR_CONF,
    parameter int ST_PARENT [NS] = DEF_ST_PARENT,
    parameter logic [NS-1:0]         ST_PAR      = DEF_ST_PAR,
    parameter logic [NS-1:0]         ST_TOPFINAL = DEF_ST_TOPFINAL,
    parameter logic [NS-1:0][NS-1:0] ST_INIT     = DEF_ST_INIT
) (
    input  logic          clk_i,
    input  logic          arst_i,
    input  logic          en_i,
    input  logic [EW-1:0] ev_id_i,
    input  logic          ev_push_i,
    output logic [NS-1:0] active_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int QCW = $clog2(QDEPTH + 1);

    logic           rst_meta, rst_q;
    phase_e         phase_q, phase_d;
    logic           init_q;
    logic [NS-1:0]  active_q, active_nx;
    logic [NT-1:0]  sel;
    logic           q_empty, q_full, q_wr, q_pop, stall, done, err_q;
    logic [EW-1:0]  q_head;
    logic [QCW-1:0] q_count;

    // Reset synchroniser: asserts at once, releases after two edges.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            rst_meta <= 1'b1;
            rst_q    <= 1'b1;
        end else begin
            rst_meta <= 1'b0;
            rst_q    <= rst_meta;
        end
    end

    stc_event_queue #(.DEPTH(QDEPTH), .W(EW), .CW(QCW)) queue_i (
        .clk(clk_i), .rst(rst_q), .push(ev_push_i), .din(ev_id_i), .pop(q_pop),
        .dout(q_head), .empty(q_empty), .full(q_full), .wr_ok(q_wr), .count(q_count)
    );

    stc_trans_select #(
        .NS(NS), .NT(NT), .NE(NE), .EW(EW),
        .TR_SRC(TR_SRC), .TR_EVT(TR_EVT), .TR_CONF(TR_CONF)
    ) select_i (
        .active(active_q), .eventless(phase_q == PH_EVENTLESS),
        .ev_valid(!q_empty), .ev_id(q_head), .sel(sel)
    );

    stc_config_next #(
        .NS(NS), .NT(NT), .TR_TGT(TR_TGT), .TR_EXIT(TR_EXIT),
        .ST_PARENT(ST_PARENT), .ST_PAR(ST_PAR), .ST_INIT(ST_INIT)
    ) config_i (
        .active(active_q), .sel(sel), .init(init_q), .next(active_nx)
    );

    // Output and control decode.
    always_comb begin
        done  = |(active_q & ST_TOPFINAL);
        stall = !en_i || done || (phase_q == PH_EVENT && q_empty);
        q_pop = (phase_q == PH_EVENT) && !stall;
    end

    always_comb begin
        phase_d = phase_q;
        if (!stall) begin
            unique case (phase_q)
                PH_EVENTLESS: phase_d = (|sel) ? PH_EVENTLESS : PH_EVENT;
                PH_EVENT:     phase_d = PH_EVENTLESS;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i or posedge rst_q) begin
        if (rst_q) begin
            phase_q  <= PH_EVENTLESS;
            init_q   <= 1'b1;
            active_q <= '0;
        end else if (!stall) begin
            phase_q  <= phase_d;
            init_q   <= 1'b0;
            active_q <= active_nx;
        end
    end

    always_ff @(posedge clk_i or posedge rst_q) begin
        if (rst_q) err_q <= 1'b0;
        else       err_q <= q_full;
    end

    assign active_o = active_q;
    assign done_o   = done;
    assign err_o    = err_q;
endmodule

// File: rtl/stc_engine_chk.sv
module stc_engine_chk import stc_pkg::*; #(
    parameter int NS = 10,
    parameter int QD = 4,
    parameter int CW = $clog2(QD + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          done,
    input logic          err,
    input logic          q_full,
    input logic          q_pop,
    input logic          q_wr,
    input logic [NS-1:0] active,
    input logic [CW-1:0] count,
    input phase_e        phase
);
    a_r9_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(active));

    a_r10_frozen_when_done: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(active));

    a_r10_no_read_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !q_pop);

    a_r12_err_follows_full: assert property (@(posedge clk) disable iff (rst)
        err == $past(q_full));

    a_r4_eventless_after_pop: assert property (@(posedge clk) disable iff (rst)
        $past(q_pop) |-> phase == PH_EVENTLESS);

    a_r12_count_drains: assert property (@(posedge clk) disable iff (rst)
        ($past(q_pop) && !$past(q_wr)) |-> count == $past(count) - CW'(1));

    a_r12_full_holds: assert property (@(posedge clk) disable iff (rst)
        (q_full && !q_pop) |=> count == CW'(QD));
endmodule

bind stc_engine stc_engine_chk #(.NS(NS), .QD(QDEPTH), .CW(QCW)) chk_i (
    .clk(clk_i), .rst(rst_q), .en(en_i), .done(done), .err(err_q),
    .q_full(q_full), .q_pop(q_pop), .q_wr(q_wr), .active(active_q),
    .count(q_count), .phase(phase_q)
);

// File: tb/stc_engine_tb_top.sv
module stc_engine_tb_top;
    logic       clk = 1'b0;
    logic       arst = 1'b1;
    logic       en = 1'b1;
    logic [2:0] ev_id = '0;
    logic       ev_push = 1'b0;
    logic [9:0] active;
    logic       done, err;
    int checks = 0;
    int errors = 0;

    localparam logic [2:0] EV_GO = 3'd0, EV_GOFAST = 3'd1, EV_FLIP = 3'd2,
                           EV_DONE = 3'd3, EV_TICK = 3'd4;

    always #4 clk = ~clk;

    stc_engine dut_i (
        .clk_i(clk), .arst_i(arst), .en_i(en), .ev_id_i(ev_id),
        .ev_push_i(ev_push), .active_o(active), .done_o(done), .err_o(err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drives the strobe for one edge; returns at the negedge after it.
    task automatic push_ev(input logic [2:0] id);
        @(negedge clk);
        ev_push = 1'b1;
        ev_id   = id;
        @(negedge clk);
        ev_push = 1'b0;
    endtask

    task automatic t_reset;
        arst = 1'b1;
        wait_cycles(2);
        check("R1 active in reset", 32'(active), 32'h0);
        check("R1 done in reset", 32'(done), 32'h0);
        check("R1 err in reset", 32'(err), 32'h0);
        arst = 1'b0;
        wait_cycles(6);
        check("R2 initial configuration", 32'(active), 32'h003);
    endtask

    task automatic t_shallow_entry;
        push_ev(EV_GO);
        @(negedge clk);
        check("R6 go enters P with default children", 32'(active), 32'h0DD);
        wait_cycles(3);
    endtask

    task automatic t_parallel_pair;
        push_ev(EV_FLIP);
        @(negedge clk);
        check("R5 T2 and T3 fire together", 32'(active), 32'h16D);
        check("R5 T5 blocked, A stays inactive", 32'(active[1]), 32'h0);
        @(negedge clk);
        check("R4 eventless T4 on following step", 32'(active), 32'h0ED);
        wait_cycles(3);
        check("R4 configuration settles", 32'(active), 32'h0ED);
    endtask

    task automatic t_wildcard;
        push_ev(EV_GOFAST);
        wait_cycles(3);
        check("R3 go.fast caught by any-event T5", 32'(active), 32'h003);
    endtask

    task automatic t_ignored;
        push_ev(EV_TICK);
        wait_cycles(4);
        check("R8 tick in A is discarded", 32'(active), 32'h003);
    endtask

    task automatic t_deep_target;
        push_ev(EV_FLIP);
        wait_cycles(4);
        check("R7 deep target P1b with P2 default", 32'(active), 32'h0ED);
    endtask

    task automatic t_enable_hold;
        @(negedge clk);
        en = 1'b0;
        push_ev(EV_DONE);
        wait_cycles(4);
        check("R9 configuration held while disabled", 32'(active), 32'h0ED);
        en = 1'b1;
        wait_cycles(4);
        check("R9 queued event processed after enable", 32'(active), 32'h003);
    endtask

    task automatic t_order;
        @(negedge clk);
        ev_push = 1'b1;
        ev_id   = EV_GOFAST;
        @(negedge clk);
        ev_id   = EV_FLIP;
        @(negedge clk);
        ev_push = 1'b0;
        wait_cycles(6);
        check("R11 go.fast then flip processed in order", 32'(active), 32'h0ED);
        check("R3 go.fast drives T1 via shared mask", 32'(active[2]), 32'h1);
    endtask

    task automatic t_final;
        push_ev(EV_DONE);
        wait_cycles(3);
        check("R10 done from P returns to A", 32'(active), 32'h003);
        check("R10 not done before final", 32'(done), 32'h0);
        push_ev(EV_DONE);
        @(negedge clk);
        check("R10 final state reached", 32'(active), 32'h201);
        check("R10 done flag", 32'(done), 32'h1);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 4; i++) push_ev(EV_GO);
        check("R12 err lags full by one clock", 32'(err), 32'h0);
        @(negedge clk);
        check("R12 err after queue filled", 32'(err), 32'h1);
        push_ev(EV_FLIP);
        wait_cycles(2);
        check("R12 err stays set while full", 32'(err), 32'h1);
        check("R10 configuration frozen when done", 32'(active), 32'h201);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        arst = 1'b1;
        #1;
        check("R13 active cleared by reset", 32'(active), 32'h0);
        check("R13 err cleared by reset", 32'(err), 32'h0);
        wait_cycles(2);
        arst = 1'b0;
        wait_cycles(6);
        check("R13 re-initialised", 32'(active), 32'h003);
        check("R13 done low again", 32'(done), 32'h0);
        check("R13 queue emptied", 32'(err), 32'h0);
    endtask

    initial begin
        t_reset();
        t_shallow_entry();
        t_parallel_pair();
        t_wildcard();
        t_ignored();
        t_deep_target();
        t_enable_hold();
        t_order();
        t_final();
        t_overflow();
        t_reset_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule